// File: doc/BRIEF.md
# Memory-Mapped IRQ/FIQ Router

This block sits between the trigger-capture logic of a 51-line interrupt controller and the processor's two interrupt inputs. It holds the per-line enable and route-select vectors. It also holds the per-line polarity vector, of which only the top four lines may be changed by software. From the raw pending vector it produces a normal interrupt output (`irq_o`) and a fast interrupt output (`fiq_o`). The capture logic supplies the raw, sense (level or edge) and dual-edge vectors. It receives the polarity vector and a one-cycle edge-clear pulse back.

Software reaches the block through a 32-bit register port. Every 51-bit vector is split into two words. Address bit 2 picks the word: the low word carries lines 31:0 and the high word carries lines 50:32. Enable has separate write-one-to-set and write-one-to-clear addresses, so software never needs a read-modify-write. Read data is registered.

Top module: `irq_fiq_router`

Register map (byte addresses, high word = address + 4): 0x00 IRQ status, 0x08 FIQ status, 0x10 raw, 0x18 edge status, 0x20 route select, 0x28 enable set, 0x30 enable clear, 0x38 sense, 0x40 dual-edge, 0x48 polarity, 0x50 edge clear, 0x58 software set, 0x60 software clear.

## Requirements
- R1: Accesses are aligned 32-bit words. Address bit 2 set selects the high word, whose bits 18:0 carry lines 50:32 and whose bits 31:19 read as zero. Read data appears on `rdata` the cycle after `rd_en` and holds until the next read.
- R2: IRQ status (0x00) reads raw AND enable AND NOT select. FIQ status (0x08) reads raw AND enable AND select.
- R3: `irq_o` is high exactly when any IRQ status bit is set. `fiq_o` is high exactly when any FIQ status bit is set.
- R4: Writing ones to the enable-set address (0x28/0x2C) sets those enable bits. Zero bits leave enable unchanged. This address reads back the enable vector.
- R5: Writing ones to the enable-clear address (0x30/0x34) clears those enable bits. Zero bits leave enable unchanged.
- R6: A write to route select (0x20/0x24) replaces only the addressed half. The other half keeps its value.
- R7: Polarity (0x48/0x4C) resets to all ones and drives `pol_o`. Only high-word bits 18:15 (lines 50:47) are writable. Every other bit, and any low-word write, is ignored.
- R8: A write to edge clear (0x50/0x54) drives `clr_o` for exactly one cycle, the cycle after the write. The pulse equals the written line bits AND NOT `sense_in`, with `sense_in` sampled at the write.
- R9: Raw (0x10), sense (0x38) and dual-edge (0x40) read back their input vectors. Edge status (0x18) reads raw AND NOT sense.
- R10: The enable-clear, edge-clear, software-set and software-clear addresses read as zero. Software-set writes have no effect.
- R11: Writes to read-only, unmapped (0x68 and above) or unaligned addresses change nothing. Reads of unmapped or unaligned addresses return zero.
- R12: Reset clears enable, select, `rdata` and `clr_o`, and sets polarity to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| raw_in | input | 51 | Raw pending vector from capture logic |
| sense_in | input | 51 | Per-line sense: 1 level, 0 edge |
| dual_in | input | 51 | Per-line dual-edge configuration |
| pol_o | output | 51 | Per-line polarity to capture logic |
| clr_o | output | 51 | One-cycle edge-clear pulse to capture logic |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that the capture vectors only change between register accesses, so a readback or status value refers to a single raw vector. The bench keeps `raw_in`, `sense_in` and `dual_in` constant through every access sequence. It issues one strobe at a time, driving on the falling edge. Unaligned and unmapped addresses are driven only as complete, well-formed single accesses.

// File: rtl/router_pkg.sv
package router_pkg;

  typedef enum logic [3:0] {
    RID_IRQ   = 4'd0,
    RID_FIQ   = 4'd1,
    RID_RAW   = 4'd2,
    RID_EDGE  = 4'd3,
    RID_SEL   = 4'd4,
    RID_ENSET = 4'd5,
    RID_ENCLR = 4'd6,
    RID_SENSE = 4'd7,
    RID_DUAL  = 4'd8,
    RID_POL   = 4'd9,
    RID_ECLR  = 4'd10,
    RID_SWSET = 4'd11,
    RID_SWCLR = 4'd12,
    RID_NONE  = 4'd15
  } reg_id_e;

  localparam int unsigned NUM_REGS = 13;

  // Moves a 32-bit word to its place in a 64-bit line vector.
  function automatic logic [63:0] spread64(input logic [31:0] d, input logic hi);
    return hi ? {d, 32'h0} : {32'h0, d};
  endfunction

  // Picks the addressed word out of a 64-bit line vector.
  function automatic logic [31:0] word64(input logic [63:0] v, input logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

endpackage

// File: rtl/reg_decode.sv
module reg_decode
  import router_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output reg_id_e           id,
  output logic              hi,
  output logic              we_sel,
  output logic              we_enset,
  output logic              we_enclr,
  output logic              we_pol,
  output logic              we_eclr
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr[ADDR_W-1:3];
  assign aligned = (addr[1:0] == 2'b00);
  assign hi      = addr[2];

  always_comb begin
    if (aligned && (int'(idx) < int'(NUM_REGS)))
      id = reg_id_e'(idx[3:0]);
    else
      id = RID_NONE;
  end

  assign we_sel   = wr_en && (id == RID_SEL);
  assign we_enset = wr_en && (id == RID_ENSET);
  assign we_enclr = wr_en && (id == RID_ENCLR);
  assign we_pol   = wr_en && (id == RID_POL);
  assign we_eclr  = wr_en && (id == RID_ECLR);

endmodule

// File: rtl/vec_regs.sv
module vec_regs #(
  parameter int          N       = 51,
  parameter int          POL_LO  = 47,
  parameter logic [N-1:0] POL_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hi,
  input  logic [31:0]  wdata,
  input  logic [N-1:0] wmask,
  input  logic         we_sel,
  input  logic         we_enset,
  input  logic         we_enclr,
  input  logic         we_pol,
  output logic [N-1:0] en,
  output logic [N-1:0] sel,
  output logic [N-1:0] pol
);
  localparam int HI_W = N - 32;
  localparam logic [N-1:0] POL_W = {{(N-POL_LO){1'b1}}, {POL_LO{1'b0}}};

  function automatic logic [N-1:0] half_replace(input logic [N-1:0] cur,
                                                input logic [31:0] d,
                                                input logic h);
    return h ? {d[HI_W-1:0], cur[31:0]} : {cur[N-1:32], d};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= '0;
      sel <= '0;
      pol <= POL_RST;
    end else begin
      if (we_enset)      en  <= en | wmask;
      else if (we_enclr) en  <= en & ~wmask;
      if (we_sel)        sel <= half_replace(sel, wdata, hi);
      if (we_pol && hi)  pol <= (pol & ~POL_W) | (wmask & POL_W);
    end
  end

  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    we_enset |=> ((en & $past(wmask)) == $past(wmask)));
  a_r4_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    we_enset |=> ((en & ~$past(wmask)) == ($past(en) & ~$past(wmask))));
  a_r5_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    we_enclr |=> ((en & $past(wmask)) == '0));
  a_r6_sel_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (we_sel && !hi) |=> $stable(sel[N-1:32]));
  a_r6_sel_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (we_sel && hi) |=> $stable(sel[31:0]));
  a_r7_pol_fixed_lines: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pol[POL_LO-1:0]));
  a_r7_pol_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_pol && hi) |=> $stable(pol));

endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int N = 51
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  input  logic [N-1:0] sense_in,
  input  logic [N-1:0] en,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] wmask,
  input  logic         we_eclr,
  output logic [N-1:0] irq_vec,
  output logic [N-1:0] fiq_vec,
  output logic [N-1:0] edge_vec,
  output logic [N-1:0] clr_o,
  output logic         irq_o,
  output logic         fiq_o
);
  logic [N-1:0] live;

  assign live     = raw_in & en;
  assign irq_vec  = live & ~sel;
  assign fiq_vec  = live & sel;
  assign edge_vec = raw_in & ~sense_in;
  assign irq_o    = |irq_vec;
  assign fiq_o    = |fiq_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)       clr_o <= '0;
    else if (we_eclr) clr_o <= wmask & ~sense_in;
    else              clr_o <= '0;
  end

  a_r3_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((raw_in & en & ~sel) != '0));
  a_r3_fiq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ((raw_in & en & sel) != '0));
  a_r8_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> $past(we_eclr));
  a_r8_pulse_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> ((clr_o & $past(sense_in)) == '0));
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |=> ((clr_o == '0) || $past(we_eclr)));

endmodule

// File: rtl/read_mux.sv
module read_mux
  import router_pkg::*;
#(
  parameter int N = 51
) (
  input  reg_id_e      id,
  input  logic         hi,
  input  logic [N-1:0] irq_vec,
  input  logic [N-1:0] fiq_vec,
  input  logic [N-1:0] raw_in,
  input  logic [N-1:0] edge_vec,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] en,
  input  logic [N-1:0] sense_in,
  input  logic [N-1:0] dual_in,
  input  logic [N-1:0] pol,
  output logic [31:0]  word
);
  logic [N-1:0] pick;

  always_comb begin
    unique case (id)
      RID_IRQ:   pick = irq_vec;
      RID_FIQ:   pick = fiq_vec;
      RID_RAW:   pick = raw_in;
      RID_EDGE:  pick = edge_vec;
      RID_SEL:   pick = sel;
      RID_ENSET: pick = en;
      RID_SENSE: pick = sense_in;
      RID_DUAL:  pick = dual_in;
      RID_POL:   pick = pol;
      default:   pick = '0;
    endcase
  end

  assign word = word64({{(64-N){1'b0}}, pick}, hi);

endmodule

// File: rtl/irq_fiq_router.sv
module irq_fiq_router
  import router_pkg::*;
#(
  parameter int           N       = 51,
  parameter int           ADDR_W  = 8,
  parameter int           POL_LO  = 47,
  parameter logic [N-1:0] POL_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [N-1:0]      raw_in,
  input  logic [N-1:0]      sense_in,
  input  logic [N-1:0]      dual_in,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      clr_o,
  output logic              irq_o,
  output logic              fiq_o
);
  reg_id_e      id;
  logic         hi;
  logic         we_sel, we_enset, we_enclr, we_pol, we_eclr;
  logic [N-1:0] wmask;
  logic [N-1:0] en, sel;
  logic [N-1:0] irq_vec, fiq_vec, edge_vec;
  logic [31:0]  rd_word;
  logic         rd_silent;

  reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .id(id), .hi(hi),
    .we_sel(we_sel), .we_enset(we_enset), .we_enclr(we_enclr),
    .we_pol(we_pol), .we_eclr(we_eclr)
  );

  assign wmask = N'(spread64(wdata, hi));

  vec_regs #(.N(N), .POL_LO(POL_LO), .POL_RST(POL_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .hi(hi), .wdata(wdata), .wmask(wmask),
    .we_sel(we_sel), .we_enset(we_enset), .we_enclr(we_enclr),
    .we_pol(we_pol), .en(en), .sel(sel), .pol(pol_o)
  );

  irq_route #(.N(N)) u_route (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .sense_in(sense_in),
    .en(en), .sel(sel), .wmask(wmask), .we_eclr(we_eclr),
    .irq_vec(irq_vec), .fiq_vec(fiq_vec), .edge_vec(edge_vec),
    .clr_o(clr_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  read_mux #(.N(N)) u_rmux (
    .id(id), .hi(hi), .irq_vec(irq_vec), .fiq_vec(fiq_vec),
    .raw_in(raw_in), .edge_vec(edge_vec), .sel(sel), .en(en),
    .sense_in(sense_in), .dual_in(dual_in), .pol(pol_o), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  assign rd_silent = (id == RID_NONE) || (id == RID_ENCLR) || (id == RID_ECLR) ||
                     (id == RID_SWSET) || (id == RID_SWCLR);

  a_r1_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  a_r1_high_word_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hi) |=> (rdata[31:N-32] == '0));
  a_r10_r11_silent_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_silent) |=> (rdata == '0));
  a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (id == RID_NONE)) |=> ($stable(en) && $stable(sel) && $stable(pol_o)));

endmodule

// File: tb/sim_irq_fiq_router.sv
module sim_irq_fiq_router;
  localparam int CLK_PERIOD = 10;
  localparam int N = 51;
  localparam int NOPS = 35;
  localparam int WDOG = 20000;

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } op_t;

  // Fixed capture vectors for the whole run.
  localparam logic [N-1:0] RAW   = {19'h40001, 32'h0000_00FF};
  localparam logic [N-1:0] SENSE = {19'h7FFFF, 32'hFFFF_0000};
  localparam logic [N-1:0] DUAL  = {19'h00003, 32'h1234_5678};

  localparam op_t OPS [NOPS] = '{
    '{1'b0, 8'h00, 32'h0,        32'h0,        4'd2},  // R2 nothing enabled
    '{1'b1, 8'h28, 32'hF,        32'h0,        4'd4},
    '{1'b0, 8'h28, 32'h0,        32'hF,        4'd4},  // R4
    '{1'b1, 8'h2C, 32'hFFFFFFFF, 32'h0,        4'd1},
    '{1'b0, 8'h2C, 32'h0,        32'h7FFFF,    4'd1},  // R1 high word padding
    '{1'b1, 8'h30, 32'h3,        32'h0,        4'd5},
    '{1'b0, 8'h28, 32'h0,        32'hC,        4'd5},  // R5
    '{1'b1, 8'h20, 32'h4,        32'h0,        4'd6},
    '{1'b1, 8'h24, 32'h1,        32'h0,        4'd6},
    '{1'b1, 8'h20, 32'h8,        32'h0,        4'd6},
    '{1'b0, 8'h24, 32'h0,        32'h1,        4'd6},  // R6 high kept
    '{1'b0, 8'h20, 32'h0,        32'h8,        4'd6},  // R6 low replaced
    '{1'b0, 8'h00, 32'h0,        32'h4,        4'd2},  // R2 irq low
    '{1'b0, 8'h08, 32'h0,        32'h8,        4'd2},  // R2 fiq low
    '{1'b0, 8'h0C, 32'h0,        32'h1,        4'd2},  // R2 fiq high
    '{1'b0, 8'h04, 32'h0,        32'h40000,    4'd2},  // R2 irq high
    '{1'b0, 8'h10, 32'h0,        32'hFF,       4'd9},  // R9 raw
    '{1'b0, 8'h1C, 32'h0,        32'h0,        4'd9},  // R9 edge high
    '{1'b0, 8'h18, 32'h0,        32'hFF,       4'd9},  // R9 edge low
    '{1'b0, 8'h38, 32'h0,        32'hFFFF0000, 4'd9},  // R9 sense
    '{1'b0, 8'h44, 32'h0,        32'h3,        4'd9},  // R9 dual high
    '{1'b0, 8'h30, 32'h0,        32'h0,        4'd10}, // R10
    '{1'b0, 8'h50, 32'h0,        32'h0,        4'd10}, // R10
    '{1'b1, 8'h58, 32'hFFFF,     32'h0,        4'd10},
    '{1'b0, 8'h58, 32'h0,        32'h0,        4'd10}, // R10
    '{1'b1, 8'h48, 32'h0,        32'h0,        4'd7},
    '{1'b0, 8'h48, 32'h0,        32'hFFFFFFFF, 4'd7},  // R7 low write ignored
    '{1'b1, 8'h4C, 32'h0,        32'h0,        4'd7},
    '{1'b0, 8'h4C, 32'h0,        32'h7FFF,     4'd7},  // R7 only 18:15 change
    '{1'b1, 8'h10, 32'h0,        32'h0,        4'd11},
    '{1'b1, 8'h70, 32'hFFFFFFFF, 32'h0,        4'd11},
    '{1'b1, 8'h29, 32'hFFFFFFFF, 32'h0,        4'd11},
    '{1'b0, 8'h28, 32'h0,        32'hC,        4'd11}, // R11 enable untouched
    '{1'b0, 8'h70, 32'h0,        32'h0,        4'd11}, // R11 unmapped
    '{1'b0, 8'h2A, 32'h0,        32'h0,        4'd11}  // R11 unaligned
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] raw_in = RAW, sense_in = SENSE, dual_in = DUAL;
  logic [N-1:0] pol_o, clr_o;
  logic         irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  irq_fiq_router u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .raw_in(raw_in), .sense_in(sense_in),
    .dual_in(dual_in), .pol_o(pol_o), .clr_o(clr_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    while (cycles < WDOG) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 rdata", 64'(rdata), 64'h0);
    check("R12 clr_o", 64'(clr_o), 64'h0);
    check("R12 irq_o", 64'(irq_o), 64'h0);
    check("R12 pol_o", 64'(pol_o), 64'({N{1'b1}}));
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NOPS; i++) begin
      if (OPS[i].wr) wr(OPS[i].a, OPS[i].d);
      else begin
        rd(OPS[i].a);
        check($sformatf("R%0d table op %0d", OPS[i].req, i), 64'(rdata), 64'(OPS[i].exp));
      end
    end

    // R3 outputs follow status: irq low bit 2, fiq low bit 3
    check("R3 irq_o set", 64'(irq_o), 64'h1);
    check("R3 fiq_o set", 64'(fiq_o), 64'h1);
    wr(8'h30, 32'hFFFFFFFF);
    wr(8'h34, 32'hFFFFFFFF);
    check("R3 irq_o cleared", 64'(irq_o), 64'h0);
    check("R3 fiq_o cleared", 64'(fiq_o), 64'h0);
    wr(8'h2C, 32'h40000);  // line 50 on, routed normal
    check("R3 irq_o line50", 64'(irq_o), 64'h1);
    check("R3 fiq_o line50", 64'(fiq_o), 64'h0);
    wr(8'h24, 32'h40000);  // line 50 to fast route
    check("R6 R3 irq_o rerouted", 64'(irq_o), 64'h0);
    check("R6 R3 fiq_o rerouted", 64'(fiq_o), 64'h1);
    check("R7 pol_o", 64'(pol_o), 64'({4'h0, {47{1'b1}}}));

    // R8 edge clear pulse
    wr(8'h50, 32'hFFFFFFFF);
    check("R8 clr_o pulse", 64'(clr_o), 64'({19'h0, 32'h0000FFFF}));
    @(negedge clk);
    check("R8 clr_o one cycle", 64'(clr_o), 64'h0);
    wr(8'h54, 32'hFFFFFFFF);
    check("R8 clr_o level lines", 64'(clr_o), 64'h0);

    // R1 read data holds without a strobe
    rd(8'h0C);
    @(negedge clk);
    @(negedge clk);
    check("R1 rdata holds", 64'(rdata), 64'h40000);

    // R12 reset mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 rdata after reset", 64'(rdata), 64'h0);
    check("R12 pol_o after reset", 64'(pol_o), 64'({N{1'b1}}));
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 irq_o after reset", 64'(irq_o), 64'h0);
    check("R12 fiq_o after reset", 64'(fiq_o), 64'h0);
    rd(8'h24);
    check("R12 select high", 64'(rdata), 64'h0);
    rd(8'h2C);
    check("R12 enable high", 64'(rdata), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule